// File: doc/BRIEF.md
# Serial Gamma Setting Register Loader

This block is the digital front end of a multi-channel gamma reference generator. A host drives three asynchronous lines: serial data, a serial clock and a latch strobe. All three are brought into the system clock domain. Each rising edge of the serial clock, taken while the latch line is low, shifts in one data bit. A rising edge of the latch line then commits the collected frame into one of nineteen 10-bit setting registers. The same event updates a flag that picks the internal or the external refresh oscillator.

A frame has 17 bits. Bit position k is the k-th bit sent, counting from 0. Position 0 is a test flag that must be zero. Position 1 is the oscillator selector. Positions 2 to 6 carry the register address and positions 7 to 16 carry the setting. The length of the frame is checked at the latch event: a frame that is too short is dropped, and an overlong one keeps only its newest 17 bits. Every register is presented in parallel on a flat output bus for the converter stage that follows.

Top module: `gamma_setting_loader`

## Requirements
- R1: After a synchronous active-low reset, all nineteen setting registers read zero and the oscillator flag reads 0 (internal).
- R2: A bit is taken on each rising edge of the serial clock, with frame bit 0 first. On the latch rising edge, a valid frame writes its setting field into the addressed register. Frame bit 7 is the most significant setting bit and frame bit 16 the least significant. Register n occupies settings_o[n*10 +: 10].
- R3: The address is frame bits 2..6, with bit 2 the most significant. Addresses 0 to 18 each select their own register.
- R4: A valid frame copies frame bit 1 to osc_ext_o, where 1 means external clock input and 0 means internal.
- R5: If fewer than 17 bits arrived since the previous latch rising edge, the latch event changes no register and leaves the oscillator flag unchanged.
- R6: If more than 17 bits arrived, only the 17 most recent bits form the frame, in arrival order.
- R7: A frame whose bit 0 (test flag) is 1 changes no register and leaves the oscillator flag unchanged.
- R8: A frame whose address is 19 or above changes no register and leaves the oscillator flag unchanged.
- R9: The bit count saturates at 17 and clears on every latch rising edge, so bits sent before a latch edge never count toward the next frame.
- R10: Serial clock edges that occur while the latch line is high shift no bit and are not counted.
- R11: A valid commit changes only the addressed register. All other registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data_i | input | 1 | Serial data line (asynchronous) |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_latch_i | input | 1 | Frame commit strobe (asynchronous) |
| settings_o | output | 190 | All setting registers, register n at bits n*10 +: 10 |
| osc_ext_o | output | 1 | Oscillator selector, 1 = external |

## Verification
The assertions check on every cycle that the bit count never passes 17, that it clears after every latch edge, and that it steps by one on each accepted serial clock edge. They also check that a rejected commit (short frame, test flag set, address out of range) leaves the whole register bank and the flag untouched, and that an accepted write lands exactly in its slot. Other behaviours need the bench's scenarios: the bit order and field positions of a frame, keeping only the last 17 bits of a long frame, and dropping a frame that was split across a latch edge or clocked in while the latch line was high. The bench covers these with directed frames and with random frames of random length, compared against a model of the register bank.

// File: rtl/gsl_pkg.sv
// Package: frame layout shared by the loader modules.
// The bit order of a frame sets the behaviour of the block, so it is fixed here.
package gsl_pkg;
    localparam int FRAME_BITS = 17;
    localparam int F_ADDR_W   = 5;
    localparam int F_DATA_W   = 10;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Frame fields after decode (data and address in natural MSB..LSB order)
    typedef struct packed {
        logic                test;
        logic                osc;
        logic [F_ADDR_W-1:0] addr;
        logic [F_DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/gsl_sync.sv
// Module: gsl_sync
// Brings W asynchronous lines into the clk domain through STAGES flops each.
// For every line it gives the synchronized level and a one-cycle rising pulse.
// Assumes each input holds a level for longer than STAGES+1 clk periods.
module gsl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_line
            logic [STAGES:0] pipe;
            // Shift chain: STAGES sync flops plus one delay flop for edge detect
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-1:0], async_i[g]};
            end
            assign level_o[g] = pipe[STAGES-1];
            assign rise_o[g]  = pipe[STAGES-1] & ~pipe[STAGES];
        end
    endgenerate
endmodule

// File: rtl/gsl_frame_shift.sv
// Module: gsl_frame_shift
// Collects serial bits into a 17-bit window and counts them.
// Newest bit enters at the top, so after 17+ bits bit 0 holds the oldest kept bit.
// Assumes data is already synchronized and aligned with the clock rise pulse.
module gsl_frame_shift
    import gsl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_i,
    input  logic   sclk_rise_i,
    input  logic   latch_lvl_i,
    input  logic   latch_rise_i,
    output frame_t frame_o,
    output logic   full_o
);
    logic [FRAME_BITS-1:0] win;
    logic [CNT_W-1:0]      cnt;
    logic                  take;

    // A bit counts only while the latch is low; a latch edge wins over a bit
    assign take = sclk_rise_i && !latch_lvl_i && !latch_rise_i;

    // Window shift: newest bit at the top, oldest falls off bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)    win <= '0;
        else if (take) win <= {bit_i, win[FRAME_BITS-1:1]};
    end

    // Bit counter: clears on latch edge, saturates at a full frame
    always_ff @(posedge clk) begin
        if (!rst_n)                                      cnt <= '0;
        else if (latch_rise_i)                           cnt <= '0;
        else if (take && cnt != CNT_W'(FRAME_BITS))      cnt <= cnt + 1'b1;
    end

    // Field decode: address and data sent MSB first
    always_comb begin
        frame_o.test = win[0];
        frame_o.osc  = win[1];
        for (int i = 0; i < F_ADDR_W; i++) frame_o.addr[F_ADDR_W-1-i] = win[2+i];
        for (int i = 0; i < F_DATA_W; i++) frame_o.data[F_DATA_W-1-i] = win[2+F_ADDR_W+i];
    end

    assign full_o = (cnt == CNT_W'(FRAME_BITS));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS));
    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise_i |=> cnt == '0);
    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise_i && !latch_lvl_i && !latch_rise_i && cnt < CNT_W'(FRAME_BITS))
        |=> cnt == $past(cnt) + 1'b1);
    // R10
    latch_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_lvl_i && !latch_rise_i) |=> $stable(win));
endmodule

// File: rtl/gsl_reg_bank.sv
// Module: gsl_reg_bank
// NUM_REGS setting registers plus the oscillator flag, all reset to zero.
// Assumes the write strobe arrives only for an address below NUM_REGS.
module gsl_reg_bank #(
    parameter int NUM_REGS = 19,
    parameter int DATA_W   = 10,
    parameter int ADDR_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic                       osc_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       osc_o
);
    genvar r;
    generate
        for (r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [DATA_W-1:0] val;
            // One setting register, written only when selected
            always_ff @(posedge clk) begin
                if (!rst_n)                                   val <= '0;
                else if (we_i && addr_i == ADDR_W'(r))        val <= data_i;
            end
            assign regs_o[r*DATA_W +: DATA_W] = val;
        end
    endgenerate

    // Oscillator flag follows every accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n)    osc_o <= 1'b0;
        else if (we_i) osc_o <= osc_i;
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> regs_o[$past(addr_i)*DATA_W +: DATA_W] == $past(data_i));
    // R4
    osc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> osc_o == $past(osc_i));
endmodule

// File: rtl/gamma_setting_loader.sv
// Module: gamma_setting_loader (top)
// Three-line serial loader for the gamma setting registers and the oscillator flag.
// Commits a frame on the latch rising edge if it is 17 bits long, has a zero test
// flag and has an address below NUM_REGS. Otherwise nothing changes.
// Assumes each serial line holds a level for several clk periods.
module gamma_setting_loader
    import gsl_pkg::*;
#(
    parameter int NUM_REGS    = 19,
    parameter int DATA_W      = F_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_data_i,
    input  logic                       ser_clk_i,
    input  logic                       ser_latch_i,
    output logic [NUM_REGS*DATA_W-1:0] settings_o,
    output logic                       osc_ext_o
);
    localparam int LINES = 3;
    localparam int L_DAT = 0;
    localparam int L_CLK = 1;
    localparam int L_LAT = 2;

    logic [LINES-1:0] lvl, rise;
    frame_t           frame;
    logic             full;
    logic             commit;

    gsl_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_latch_i, ser_clk_i, ser_data_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    gsl_frame_shift u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_i        (lvl[L_DAT]),
        .sclk_rise_i  (rise[L_CLK]),
        .latch_lvl_i  (lvl[L_LAT]),
        .latch_rise_i (rise[L_LAT]),
        .frame_o      (frame),
        .full_o       (full)
    );

    // Frame acceptance at the latch edge
    assign commit = rise[L_LAT] && full && !frame.test &&
                    (frame.addr < F_ADDR_W'(NUM_REGS));

    gsl_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(F_ADDR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (commit),
        .addr_i (frame.addr),
        .data_i (DATA_W'(frame.data)),
        .osc_i  (frame.osc),
        .regs_o (settings_o),
        .osc_o  (osc_ext_o)
    );

    // R5
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[L_LAT] && !full) |=> ($stable(settings_o) && $stable(osc_ext_o)));
    // R7
    test_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[L_LAT] && frame.test) |=> ($stable(settings_o) && $stable(osc_ext_o)));
    // R8
    addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[L_LAT] && frame.addr >= F_ADDR_W'(NUM_REGS)) |=>
        ($stable(settings_o) && $stable(osc_ext_o)));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise[L_LAT] |=> ($stable(settings_o) && $stable(osc_ext_o)));
endmodule

// File: tb/tb_gamma_setting_loader.sv
module tb_gamma_setting_loader;
    localparam int NR = 19;
    localparam int DW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd = 1'b0, sc = 1'b0, sl = 1'b0;
    logic [NR*DW-1:0] settings;
    logic osc;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] exp_r [NR];
    logic exp_osc;

    always #5 clk = ~clk;

    gamma_setting_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_data_i(sd), .ser_clk_i(sc),
        .ser_latch_i(sl), .settings_o(settings), .osc_ext_o(osc)
    );

    // Build a frame: bit k is the k-th bit sent
    function automatic logic [16:0] mk(input logic t, input logic o,
                                       input logic [4:0] a, input logic [9:0] d);
        logic [16:0] f;
        f[0] = t;
        f[1] = o;
        for (int i = 0; i < 5; i++)  f[2+i] = a[4-i];
        for (int i = 0; i < 10; i++) f[7+i] = d[9-i];
        return f;
    endfunction

    function automatic logic [NR*DW-1:0] exp_vec();
        logic [NR*DW-1:0] v;
        for (int i = 0; i < NR; i++) v[i*DW +: DW] = exp_r[i];
        return v;
    endfunction

    task automatic put_bit(input logic b);
        @(negedge clk); sd = b;
        repeat (3) @(negedge clk);
        sc = 1'b1;
        repeat (4) @(negedge clk);
        sc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_latch();
        @(negedge clk); sl = 1'b1;
        repeat (8) @(negedge clk);
        sl = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Model: apply the rules to the n bits sent since the last latch
    task automatic model(input logic [63:0] bits, input int n);
        logic [16:0] f;
        logic [4:0] a;
        logic [9:0] d;
        if (n < 17) return;
        f = bits[n-17 +: 17];
        for (int i = 0; i < 5; i++)  a[4-i] = f[2+i];
        for (int i = 0; i < 10; i++) d[9-i] = f[7+i];
        if (f[0] == 1'b0 && a < 5'd19) begin
            exp_r[a] = d;
            exp_osc  = f[1];
        end
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        for (int i = 0; i < n; i++) put_bit(bits[i]);
        pulse_latch();
        model(bits, n);
    endtask

    task automatic check(input string tag);
        checks++;
        if (settings !== exp_vec()) begin
            failures++;
            $display("FAIL %s settings actual=%h expected=%h", tag, settings, exp_vec());
        end
        checks++;
        if (osc !== exp_osc) begin
            failures++;
            $display("FAIL %s osc actual=%b expected=%b", tag, osc, exp_osc);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [16:0] f;
        logic [63:0] bits;
        int n;
        void'($urandom(32'd2024));
        for (int i = 0; i < NR; i++) exp_r[i] = '0;
        exp_osc = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1");

        send(64'(mk(1'b0, 1'b0, 5'd0, 10'h2A5)), 17);
        check("R2");
        send(64'(mk(1'b0, 1'b0, 5'd18, 10'h3FF)), 17);
        send(64'(mk(1'b0, 1'b0, 5'd16, 10'h001)), 17);
        check("R3");
        send(64'(mk(1'b0, 1'b1, 5'd5, 10'h133)), 17);
        check("R4");
        send(64'(mk(1'b0, 1'b0, 5'd6, 10'h0F0)), 17);
        check("R4");

        // R5: 16-bit frame is dropped
        send(64'(mk(1'b0, 1'b1, 5'd3, 10'h155)), 16);
        check("R5");
        // R6: three leading junk bits, then a frame
        send({47'd0, mk(1'b0, 1'b1, 5'd9, 10'h2C3)} << 3 | 64'h5, 20);
        check("R6");
        // R7: test flag set
        send(64'(mk(1'b1, 1'b0, 5'd2, 10'h3AA)), 17);
        check("R7");
        // R8: out-of-range addresses
        send(64'(mk(1'b0, 1'b0, 5'd19, 10'h111)), 17);
        send(64'(mk(1'b0, 1'b0, 5'd31, 10'h222)), 17);
        check("R8");

        // R9: frame split across a latch edge is dropped
        f = mk(1'b0, 1'b0, 5'd4, 10'h3C3);
        send(64'(f), 10);
        send(64'(f[16:10]), 7);
        check("R9");

        // R10: bits clocked while latch is high do not count
        @(negedge clk); sl = 1'b1;
        repeat (6) @(negedge clk);
        f = mk(1'b0, 1'b1, 5'd7, 10'h0AB);
        for (int i = 0; i < 17; i++) put_bit(f[i]);
        sl = 1'b0;
        repeat (6) @(negedge clk);
        pulse_latch();
        check("R10");

        // R11: random frames, random lengths, mostly valid
        for (int k = 0; k < 45; k++) begin
            n = 14 + int'($urandom_range(8));
            f = mk(($urandom_range(7) == 0), 1'($urandom()),
                   5'($urandom_range(22)), 10'($urandom()));
            if (n >= 17) bits = (64'(f) << (n-17)) | (64'($urandom()) & ((64'd1 << (n-17)) - 1));
            else         bits = 64'(f);
            send(bits, n);
            check("R11");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule